// File: doc/BRIEF.md
# Exception Cause and Vector Unit

This block gathers every exception request of a small RISC core in one place and issues at most one exception entry per clock. Requests come from the decode flags of the retiring instruction, read against the machine-state bits (floating-point available, user state, external enable, single-step trace, branch trace). Other requests are the instruction and data translation-miss strobes, an alignment-fault strobe and the internal decrementer. A fixed priority picks one winner. One cycle later the block raises a take pulse together with a 20-bit vector offset and, for program exceptions, a one-hot subtype that says why the instruction faulted.

The decrementer timer is part of the block. Software loads it through a write port, and it counts down by one on each enabled timebase tick. The unit watches its most significant bit for a 0-to-1 change, which raises a timer request. If a higher-priority exception wins the same cycle, the timer request stays pending. It is dropped only when it is finally taken or when external enable goes low. Flushing the pipeline, saving machine state and the translation lookups themselves belong to other blocks.

Top module: `exc_vector_unit`

## Requirements
- R1: After reset `takeExc` is 0, `vecOff` is 0, `subType` is 0 and `decValue` is 0.
- R2: The cycle after a cause is present, `takeExc` is 1 for one cycle and `vecOff` holds: alignment 0x00600, program 0x00700, FP unavailable 0x00800, decrementer 0x00900, system call 0x00C00, trace 0x00D00, instruction TLB miss 0x01000, data TLB miss 0x01100. With no cause, `takeExc`, `vecOff` and `subType` are 0. The offsets 0x00E00, 0x00A00–0x00BFF and 0x00E10–0x00FFF are never produced.
- R3: `subType` is one-hot and non-zero only with vector 0x00700. Bit 0 means illegal opcode, bit 1 privileged instruction and bit 2 trap. When several apply, illegal wins over privileged, and privileged wins over trap.
- R4: A privileged program exception is raised when `instValid`, `msrUser` and either `isPriv`, or `isSprMove` with `sprPrivBit`=1. Nothing is raised in supervisor state or for a special-register move with `sprPrivBit`=0.
- R5: `instValid` with `isFpOp` and `msrFp`=0 raises vector 0x00800. With `msrFp`=1 there is no exception.
- R6: `instValid` with `isSysCall` raises vector 0x00C00 whatever the state bits are.
- R7: Trace (0x00D00) is raised by a valid instruction when `msrStep`=1, or when `isBranch` and `msrBrTrace` are both 1. A non-branch with only `msrBrTrace` set raises nothing. Without `instValid` there is no trace.
- R8: Priority runs from highest to lowest: instruction TLB miss; then, for the instruction, program, FP unavailable, system call; then alignment, data TLB miss, trace and decrementer.
- R9: On a clock with `decWrEn` the decrementer loads `decWrData`. Otherwise on `tbTick` it decreases by one, wrapping from 0 to all ones. The current value is on `decValue`.
- R10: A decrementer exception is requested once, in the cycle after the decrementer's top bit goes from 0 to 1, and only while `msrExtEn`=1. An edge seen with `msrExtEn`=0 is lost.
- R11: A decrementer request that loses to a higher-priority cause stays pending and is taken on a later free cycle. It is dropped in any cycle where `msrExtEn`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | A retiring instruction is present |
| isIllegal | input | 1 | Instruction is illegal or unimplemented |
| isPriv | input | 1 | Instruction is privileged |
| isTrap | input | 1 | Trap instruction whose condition is met |
| isFpOp | input | 1 | Floating-point instruction, load, store or move |
| isSprMove | input | 1 | Move to or from a special register |
| sprPrivBit | input | 1 | Top bit of the special-register number field |
| isSysCall | input | 1 | System call instruction |
| isBranch | input | 1 | Branch instruction |
| msrFp | input | 1 | Floating-point available |
| msrUser | input | 1 | User (problem) state |
| msrExtEn | input | 1 | External exceptions enabled |
| msrStep | input | 1 | Single-step trace enabled |
| msrBrTrace | input | 1 | Branch trace enabled |
| itlbMiss | input | 1 | Instruction translation miss strobe |
| dtlbMiss | input | 1 | Data-load translation miss strobe |
| alignFault | input | 1 | Alignment fault strobe |
| tbTick | input | 1 | Timebase tick, decrements the decrementer |
| decWrEn | input | 1 | Load strobe for the decrementer |
| decWrData | input | 32 | Decrementer load value |
| takeExc | output | 1 | Exception taken this cycle |
| vecOff | output | 20 | Vector offset of the taken exception |
| subType | output | 3 | One-hot program subtype |
| decValue | output | 32 | Current decrementer value |

## Verification
Each cause is first driven alone, so that a wrong offset or a missing gate shows up by itself. Examples are FP instructions with the available bit set and clear, special-register moves with the top number bit at 0 and 1 in both privilege states, and branch and non-branch instructions under branch trace. Pairs and triples of simultaneous causes then separate each priority step from its neighbour. The decrementer is loaded, counted down and wrapped through its top bit in three settings: with external enable on, with it off, and with a competing alignment fault. These show a single request per edge, a request held across a lost arbitration, and a request dropped when enable falls.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int VEC_W = 20;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ITLB, SEL_PROG, SEL_FPU, SEL_SC,
    SEL_ALIGN, SEL_DTLB, SEL_TRACE, SEL_DEC
  } excSel_e;

  typedef struct packed {
    logic    take;
    excSel_e sel;
    logic [2:0] sub;   // one-hot: 0 illegal, 1 privileged, 2 trap
  } excStrobe_t;

  function automatic logic [VEC_W-1:0] vecFor(input excSel_e s);
    case (s)
      SEL_ALIGN: vecFor = VEC_W'('h00600);
      SEL_PROG:  vecFor = VEC_W'('h00700);
      SEL_FPU:   vecFor = VEC_W'('h00800);
      SEL_DEC:   vecFor = VEC_W'('h00900);
      SEL_SC:    vecFor = VEC_W'('h00C00);
      SEL_TRACE: vecFor = VEC_W'('h00D00);
      SEL_ITLB:  vecFor = VEC_W'('h01000);
      SEL_DTLB:  vecFor = VEC_W'('h01100);
      default:   vecFor = '0;
    endcase
  endfunction
endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
(
  input  logic instValid,
  input  logic isIllegal,
  input  logic isPriv,
  input  logic isTrap,
  input  logic isFpOp,
  input  logic isSprMove,
  input  logic sprPrivBit,
  input  logic isSysCall,
  input  logic isBranch,
  input  logic msrFp,
  input  logic msrUser,
  input  logic msrStep,
  input  logic msrBrTrace,
  input  logic itlbMiss,
  input  logic dtlbMiss,
  input  logic alignFault,
  input  logic decReq,
  output excStrobe_t strb
);
  logic progIll, progPriv, progTrap, fpUnavail, sysCall, traceHit;

  always_comb begin
    progIll   = instValid & isIllegal;
    progPriv  = instValid & msrUser & (isPriv | (isSprMove & sprPrivBit));
    progTrap  = instValid & isTrap;
    fpUnavail = instValid & isFpOp & ~msrFp;
    sysCall   = instValid & isSysCall;
    traceHit  = instValid & (msrStep | (isBranch & msrBrTrace));
  end

  always_comb begin
    strb = '{take: 1'b1, sel: SEL_NONE, sub: 3'b000};
    if (itlbMiss)                           strb.sel = SEL_ITLB;
    else if (progIll | progPriv | progTrap) begin
      strb.sel = SEL_PROG;
      if (progIll)       strb.sub = 3'b001;
      else if (progPriv) strb.sub = 3'b010;
      else               strb.sub = 3'b100;
    end
    else if (fpUnavail)                     strb.sel = SEL_FPU;
    else if (sysCall)                       strb.sel = SEL_SC;
    else if (alignFault)                    strb.sel = SEL_ALIGN;
    else if (dtlbMiss)                      strb.sel = SEL_DTLB;
    else if (traceHit)                      strb.sel = SEL_TRACE;
    else if (decReq)                        strb.sel = SEL_DEC;
    else                                    strb.take = 1'b0;
  end
endmodule

// File: rtl/exc_dpath.sv
module exc_dpath
  import exc_pkg::*;
#(
  parameter int DEC_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  excStrobe_t       strb,
  input  logic             msrExtEn,
  input  logic             tbTick,
  input  logic             decWrEn,
  input  logic [DEC_W-1:0] decWrData,
  output logic             decReq,
  output logic             takeExc,
  output logic [VEC_W-1:0] vecOff,
  output logic [2:0]       subType,
  output logic [DEC_W-1:0] decValue
);
  localparam int MSB = DEC_W - 1;

  logic [DEC_W-1:0] decCnt;
  logic             prevMsb;
  logic             decPend;
  logic             msbEdge;

  assign msbEdge  = decCnt[MSB] & ~prevMsb;
  assign decReq   = msrExtEn & (decPend | msbEdge);
  assign decValue = decCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decCnt  <= '0;
      prevMsb <= 1'b0;
      decPend <= 1'b0;
      takeExc <= 1'b0;
      vecOff  <= '0;
      subType <= '0;
    end else begin
      prevMsb <= decCnt[MSB];
      if (decWrEn)     decCnt <= decWrData;
      else if (tbTick) decCnt <= decCnt - 1'b1;
      decPend <= decReq & (strb.sel != SEL_DEC);
      takeExc <= strb.take;
      vecOff  <= vecFor(strb.sel);
      subType <= strb.sub;
    end
  end
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_pkg::*;
#(
  parameter int DEC_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic             isIllegal,
  input  logic             isPriv,
  input  logic             isTrap,
  input  logic             isFpOp,
  input  logic             isSprMove,
  input  logic             sprPrivBit,
  input  logic             isSysCall,
  input  logic             isBranch,
  input  logic             msrFp,
  input  logic             msrUser,
  input  logic             msrExtEn,
  input  logic             msrStep,
  input  logic             msrBrTrace,
  input  logic             itlbMiss,
  input  logic             dtlbMiss,
  input  logic             alignFault,
  input  logic             tbTick,
  input  logic             decWrEn,
  input  logic [DEC_W-1:0] decWrData,
  output logic             takeExc,
  output logic [VEC_W-1:0] vecOff,
  output logic [2:0]       subType,
  output logic [DEC_W-1:0] decValue
);
  excStrobe_t strb;
  logic       decReq;

  exc_ctrl uCtrl (
    .instValid(instValid), .isIllegal(isIllegal), .isPriv(isPriv),
    .isTrap(isTrap), .isFpOp(isFpOp), .isSprMove(isSprMove),
    .sprPrivBit(sprPrivBit), .isSysCall(isSysCall), .isBranch(isBranch),
    .msrFp(msrFp), .msrUser(msrUser), .msrStep(msrStep),
    .msrBrTrace(msrBrTrace), .itlbMiss(itlbMiss), .dtlbMiss(dtlbMiss),
    .alignFault(alignFault), .decReq(decReq), .strb(strb)
  );

  exc_dpath #(.DEC_W(DEC_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .msrExtEn(msrExtEn),
    .tbTick(tbTick), .decWrEn(decWrEn), .decWrData(decWrData),
    .decReq(decReq), .takeExc(takeExc), .vecOff(vecOff),
    .subType(subType), .decValue(decValue)
  );
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk #(
  parameter int DEC_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             instValid,
  input logic             isSysCall,
  input logic             itlbMiss,
  input logic             tbTick,
  input logic             decWrEn,
  input logic [DEC_W-1:0] decWrData,
  input logic             takeExc,
  input logic [19:0]      vecOff,
  input logic [2:0]       subType,
  input logic [DEC_W-1:0] decValue
);
  AST_SUB_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(subType)); // R3

  AST_SUB_ONLY_PROG: assert property (@(posedge clk) disable iff (!rstN)
    (subType != 3'b000) |-> (takeExc && vecOff == 20'h00700)); // R3

  AST_NO_RESERVED_VEC: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |-> (vecOff != 20'h00E00 && !(vecOff >= 20'h00A00 && vecOff <= 20'h00BFF)
                 && !(vecOff >= 20'h00E10 && vecOff <= 20'h00FFF))); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !takeExc |-> (vecOff == 20'h0 && subType == 3'b000)); // R2

  AST_ITLB_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    itlbMiss |=> (takeExc && vecOff == 20'h01000)); // R8

  AST_SYSCALL_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && isSysCall) |=> takeExc); // R6

  AST_DEC_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    decWrEn |=> (decValue == $past(decWrData))); // R9

  AST_DEC_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!decWrEn && tbTick) |=> (decValue == DEC_W'($past(decValue) - 1'b1))); // R9
endmodule

bind exc_vector_unit exc_vector_unit_chk #(.DEC_W(DEC_W)) uChk (.*);

// File: tb/tb_exc_vector_unit.sv
`timescale 1ns/1ps
module tb_exc_vector_unit;
  typedef struct packed {
    logic instValid, isIllegal, isPriv, isTrap, isFpOp, isSprMove, sprPrivBit;
    logic isSysCall, isBranch, msrFp, msrUser, msrExtEn, msrStep, msrBrTrace;
    logic itlbMiss, dtlbMiss, alignFault, tbTick, decWrEn;
    logic [31:0] decWrData;
  } stim_t;

  typedef struct {
    logic        take;
    logic [19:0] vec;
    logic [2:0]  sub;
    logic [31:0] dec;
    string       tag;
  } exp_t;

  logic clk = 0, rstN = 0;
  stim_t s = '0;
  logic takeExc;
  logic [19:0] vecOff;
  logic [2:0] subType;
  logic [31:0] decValue;

  int checks = 0, fails = 0;
  bit done = 0;
  exp_t sbq[$];

  logic [31:0] mDec = 0;
  logic        mPrev = 0, mPend = 0;

  always #4 clk = ~clk;

  exc_vector_unit dut (
    .clk(clk), .rstN(rstN), .instValid(s.instValid), .isIllegal(s.isIllegal),
    .isPriv(s.isPriv), .isTrap(s.isTrap), .isFpOp(s.isFpOp),
    .isSprMove(s.isSprMove), .sprPrivBit(s.sprPrivBit), .isSysCall(s.isSysCall),
    .isBranch(s.isBranch), .msrFp(s.msrFp), .msrUser(s.msrUser),
    .msrExtEn(s.msrExtEn), .msrStep(s.msrStep), .msrBrTrace(s.msrBrTrace),
    .itlbMiss(s.itlbMiss), .dtlbMiss(s.dtlbMiss), .alignFault(s.alignFault),
    .tbTick(s.tbTick), .decWrEn(s.decWrEn), .decWrData(s.decWrData),
    .takeExc(takeExc), .vecOff(vecOff), .subType(subType), .decValue(decValue)
  );

  // Driver: applies one cycle of stimulus and pushes the expected result
  task automatic step(input stim_t st, input string tag);
    exp_t e;
    logic edgeHit, dReq, pIll, pPriv, pTrap;
    @(negedge clk);
    s = st;
    edgeHit = mDec[31] & ~mPrev;
    dReq  = st.msrExtEn & (mPend | edgeHit);
    pIll  = st.instValid & st.isIllegal;
    pPriv = st.instValid & st.msrUser & (st.isPriv | (st.isSprMove & st.sprPrivBit));
    pTrap = st.instValid & st.isTrap;
    e.take = 1; e.sub = 3'b000; e.tag = tag;
    if (st.itlbMiss) e.vec = 20'h01000;
    else if (pIll | pPriv | pTrap) begin
      e.vec = 20'h00700;
      e.sub = pIll ? 3'b001 : (pPriv ? 3'b010 : 3'b100);
    end
    else if (st.instValid & st.isFpOp & ~st.msrFp) e.vec = 20'h00800;
    else if (st.instValid & st.isSysCall)          e.vec = 20'h00C00;
    else if (st.alignFault)                        e.vec = 20'h00600;
    else if (st.dtlbMiss)                          e.vec = 20'h01100;
    else if (st.instValid & (st.msrStep | (st.isBranch & st.msrBrTrace))) e.vec = 20'h00D00;
    else if (dReq)                                 e.vec = 20'h00900;
    else begin e.take = 0; e.vec = 20'h0; end
    mPend = dReq & (e.vec != 20'h00900);
    mPrev = mDec[31];
    if (st.decWrEn)     mDec = st.decWrData;
    else if (st.tbTick) mDec = mDec - 1;
    e.dec = mDec;
    sbq.push_back(e);
  endtask

  // Monitor: pops and compares after each active edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #2;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        checks++;
        if (takeExc !== e.take || vecOff !== e.vec || subType !== e.sub || decValue !== e.dec) begin
          fails++;
          $display("FAIL %s: got take=%0b vec=%h sub=%b dec=%h, expected take=%0b vec=%h sub=%b dec=%h",
                   e.tag, takeExc, vecOff, subType, decValue, e.take, e.vec, e.sub, e.dec);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    stim_t t;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checks++;
    if (takeExc !== 0 || vecOff !== 0 || subType !== 0 || decValue !== 0) begin
      fails++;
      $display("FAIL R1: got take=%0b vec=%h sub=%b dec=%h, expected all zero",
               takeExc, vecOff, subType, decValue);
    end

    t = '0; step(t, "R2 idle");
    t = '0; t.itlbMiss = 1; step(t, "R2 itlb");
    t = '0; t.dtlbMiss = 1; step(t, "R2 dtlb");
    t = '0; t.alignFault = 1; step(t, "R2 align");
    t = '0; step(t, "R2 idle after");

    t = '0; t.instValid = 1; t.isIllegal = 1; step(t, "R3 illegal");
    t = '0; t.instValid = 1; t.isIllegal = 1; t.isTrap = 1; step(t, "R3 illegal beats trap");
    t = '0; t.instValid = 1; t.isTrap = 1; step(t, "R3 trap");
    t = '0; t.instValid = 1; t.isPriv = 1; t.isTrap = 1; t.msrUser = 1; step(t, "R3 priv beats trap");

    t = '0; t.instValid = 1; t.isPriv = 1; t.msrUser = 1; step(t, "R4 priv user");
    t = '0; t.instValid = 1; t.isPriv = 1; step(t, "R4 priv supervisor");
    t = '0; t.instValid = 1; t.isSprMove = 1; t.sprPrivBit = 1; t.msrUser = 1; step(t, "R4 spr top bit user");
    t = '0; t.instValid = 1; t.isSprMove = 1; t.msrUser = 1; step(t, "R4 spr bit clear user");
    t = '0; t.instValid = 1; t.isSprMove = 1; t.sprPrivBit = 1; step(t, "R4 spr supervisor");
    t = '0; t.isPriv = 1; t.msrUser = 1; step(t, "R4 no instValid");

    t = '0; t.instValid = 1; t.isFpOp = 1; step(t, "R5 fp unavailable");
    t = '0; t.instValid = 1; t.isFpOp = 1; t.msrFp = 1; step(t, "R5 fp available");

    t = '0; t.instValid = 1; t.isSysCall = 1; step(t, "R6 syscall supervisor");
    t = '0; t.instValid = 1; t.isSysCall = 1; t.msrUser = 1; t.msrFp = 1; step(t, "R6 syscall user");

    t = '0; t.instValid = 1; t.msrStep = 1; step(t, "R7 single step");
    t = '0; t.instValid = 1; t.isBranch = 1; t.msrBrTrace = 1; step(t, "R7 branch trace");
    t = '0; t.instValid = 1; t.msrBrTrace = 1; step(t, "R7 non-branch");
    t = '0; t.msrStep = 1; t.isBranch = 1; t.msrBrTrace = 1; step(t, "R7 no instValid");

    t = '0; t.itlbMiss = 1; t.instValid = 1; t.isIllegal = 1; step(t, "R8 itlb over program");
    t = '0; t.instValid = 1; t.isTrap = 1; t.isFpOp = 1; t.isSysCall = 1; step(t, "R8 program over fp");
    t = '0; t.instValid = 1; t.isFpOp = 1; t.isSysCall = 1; step(t, "R8 fp over syscall");
    t = '0; t.instValid = 1; t.isSysCall = 1; t.alignFault = 1; step(t, "R8 syscall over align");
    t = '0; t.alignFault = 1; t.dtlbMiss = 1; step(t, "R8 align over dtlb");
    t = '0; t.dtlbMiss = 1; t.instValid = 1; t.msrStep = 1; step(t, "R8 dtlb over trace");

    t = '0; t.decWrEn = 1; t.decWrData = 32'h5; step(t, "R9 load");
    t = '0; t.tbTick = 1; step(t, "R9 tick");
    t = '0; step(t, "R9 hold");
    t = '0; t.tbTick = 1; t.decWrEn = 1; t.decWrData = 32'h1234; step(t, "R9 load beats tick");

    t = '0; t.msrExtEn = 1; t.decWrEn = 1; t.decWrData = 32'h1; step(t, "R10 load one");
    t = '0; t.msrExtEn = 1; t.tbTick = 1; step(t, "R10 tick to zero");
    t = '0; t.msrExtEn = 1; t.tbTick = 1; step(t, "R10 wrap");
    t = '0; t.msrExtEn = 1; t.tbTick = 1; step(t, "R10 edge taken");
    t = '0; t.msrExtEn = 1; step(t, "R10 single request");
    t = '0; t.decWrEn = 1; t.decWrData = 32'h0; step(t, "R10 reload disabled");
    t = '0; t.tbTick = 1; step(t, "R10 wrap disabled");
    t = '0; step(t, "R10 edge lost");
    t = '0; t.msrExtEn = 1; step(t, "R10 no late request");

    t = '0; t.msrExtEn = 1; t.decWrEn = 1; t.decWrData = 32'h0; step(t, "R11 reload");
    t = '0; t.msrExtEn = 1; t.tbTick = 1; step(t, "R11 wrap");
    t = '0; t.msrExtEn = 1; t.alignFault = 1; step(t, "R11 align wins");
    t = '0; t.msrExtEn = 1; t.dtlbMiss = 1; step(t, "R11 dtlb wins");
    t = '0; t.msrExtEn = 1; step(t, "R11 pending taken");
    t = '0; t.msrExtEn = 1; t.decWrEn = 1; t.decWrData = 32'h0; step(t, "R11 reload again");
    t = '0; t.msrExtEn = 1; t.tbTick = 1; step(t, "R11 wrap again");
    t = '0; t.msrExtEn = 1; t.alignFault = 1; step(t, "R11 align wins again");
    t = '0; step(t, "R11 enable cleared");
    t = '0; t.msrExtEn = 1; step(t, "R11 dropped");

    t = '0; step(t, "R2 final idle");
    while (sbq.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule